// File: doc/BRIEF.md
# Instruction issue and skip sequencer

This block paces a stream of 24-bit instruction words for a small 16-bit controller core. Each cycle it looks at the word fetched from the current program counter, sorts it into a class by its top byte, and decides whether the word is executed, replaced by a bubble (a NOP cycle), or stretched over more cycles. It also owns the program counter: it steps by two per word, jumps to a supplied target for taken branches and returns, and holds while bubbles drain.

The core supplies a condition result for skip and conditional-branch instructions and a branch target. Both are sampled in the issue cycle of the instruction that uses them. The sequencer reports an execute strobe on the first cycle of each executed instruction and a bubble strobe on every NOP cycle. On the final cycle of each instruction it raises a last strobe together with the number of cycles that instruction took. A word whose top byte is zero is the tail of a two-word instruction. When the PC lands on such a word by itself, it runs as a one-cycle NOP. When a skip is taken, the sequencer checks the top byte of the word being skipped. If that word opens a two-word instruction, the skip consumes both words.

Top module: `issue_seq_top`

## Requirements
- R1: The opcode is bits 23:16 of the word. With the default encodings the classes are: two-word 0x02-0x03, jump 0x04-0x07, return 0x08-0x09, conditional branch 0x30-0x3F, skip 0xA0-0xAF, table 0xB8-0xBF, stray tail 0x00, and normal for any other value. A stray tail word takes one cycle with nop_o high and exec_o low, and the PC advances by 2.
- R2: A normal word takes one cycle with exec_o high, last_o high and ncyc_o=1, and the PC advances by 2.
- R3: A two-word instruction has exec_o high in its first cycle. In its second cycle exec_o and nop_o are both low. The next word is consumed whatever its contents, ncyc_o=2, and the PC advances by 4 in total.
- R4: A skip whose cond_i is low in its issue cycle takes one cycle, and the PC advances by 2.
- R5: A taken skip over a one-word instruction adds one bubble cycle with the PC at the skipped word, ncyc_o=2, and the PC advances by 4 in total. The class, cond_i and target_i of the skipped word have no effect.
- R6: A taken skip over a word that opens a two-word instruction adds two bubble cycles, ncyc_o=3, and the PC advances by 6 in total.
- R7: A conditional branch with cond_i low takes one cycle and the PC advances by 2. With cond_i high, the PC loads target_i as sampled at issue, and one bubble follows with the PC at the target (ncyc_o=2).
- R8: A jump always behaves like a taken conditional branch: the PC loads the target, one bubble follows, and ncyc_o=2.
- R9: A return loads target_i and is followed by two bubble cycles with the PC held at the target, and ncyc_o=3.
- R10: A table instruction is followed by one bubble with the PC already at the next word, and ncyc_o=2.
- R11: last_o is high only on the final cycle of an instruction, and ncyc_o is then between 1 and 3. exec_o and nop_o are never high together.
- R12: A synchronous active-low reset sets the PC to 0 and drops any pending bubble or second-word cycle. The first cycle after release issues the word at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_i | input | 24 | Word fetched at pc_o |
| cond_i | input | 1 | Condition result for the skip or branch at issue |
| target_i | input | 16 | Branch or return target, sampled at issue |
| pc_o | output | 16 | Program counter (byte address, even) |
| exec_o | output | 1 | First cycle of an executed instruction |
| nop_o | output | 1 | Bubble cycle |
| last_o | output | 1 | Final cycle of the current instruction |
| ncyc_o | output | 2 | Cycle count of the instruction ending now |

## Verification
Two events can meet in one cycle: a taken skip looks at the next word's class at the same moment that word could issue as a branch or a two-word instruction. The bench provokes this in three ways. It places a conditional branch with its condition true under a taken skip. It places a two-word instruction whose second word looks like a branch under a taken skip. It places a jump-looking word in the tail of a two-word instruction. A behavioural model in the bench works out from the program image how many cycles each instruction should take and what the PC and strobes should be, and it compares these with the outputs every cycle. A reset is also asserted in the middle of a three-cycle instruction, to show that the pending bubbles are dropped.

// File: rtl/issue_seq_pkg.sv
// Shared types for the issue sequencer.
// Assumes: eight instruction classes, six sequencer states, three PC actions.
package issue_seq_pkg;

    typedef enum logic [2:0] {
        CL_STRAY  = 3'd0,
        CL_NORMAL = 3'd1,
        CL_DWORD  = 3'd2,
        CL_SKIP   = 3'd3,
        CL_CBR    = 3'd4,
        CL_JUMP   = 3'd5,
        CL_RET    = 3'd6,
        CL_TBL    = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        ST_ISSUE = 3'd0,
        ST_DW2   = 3'd1,
        ST_SK1   = 3'd2,
        ST_SK2   = 3'd3,
        ST_FL2   = 3'd4,
        ST_FL1   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_LOAD = 2'd2
    } pc_sel_e;

    // Number of matchable classes in the match/mask tables.
    localparam int unsigned N_MATCH = 6;

    // Table slot to class mapping (slot 0 has highest priority).
    function automatic op_class_e slot_class(input int unsigned slot);
        case (slot)
            0:       return CL_DWORD;
            1:       return CL_SKIP;
            2:       return CL_CBR;
            3:       return CL_JUMP;
            4:       return CL_RET;
            default: return CL_TBL;
        endcase
    endfunction

endpackage

// File: rtl/issue_opc_class.sv
// Opcode classifier.
// Sorts an opcode into a class using a match/mask pair per class.
// Assumes: an all-zero opcode is always a stray second word; lower slot wins on overlap;
// an opcode that hits no slot is a normal instruction.
module issue_opc_class
    import issue_seq_pkg::*;
#(
    parameter int unsigned         OPC_W     = 8,
    parameter logic [6*OPC_W-1:0] CLS_MATCH = 48'hB8_08_04_30_A0_02,
    parameter logic [6*OPC_W-1:0] CLS_MASK  = 48'hF8_FE_FC_F0_F0_FE
) (
    input  logic [OPC_W-1:0] opc_i,
    output op_class_e        cls_o
);

    logic [N_MATCH-1:0] hit;

    // One comparator per class slot.
    for (genvar s = 0; s < N_MATCH; s++) begin : g_slot
        assign hit[s] = (opc_i & CLS_MASK[s*OPC_W +: OPC_W]) == CLS_MATCH[s*OPC_W +: OPC_W];
    end

    // Priority pick: zero opcode first, then the lowest slot that hits.
    always_comb begin
        cls_o = CL_NORMAL;
        for (int s = N_MATCH - 1; s >= 0; s--) begin
            if (hit[s]) cls_o = slot_class(s);
        end
        if (opc_i == '0) cls_o = CL_STRAY;
    end

endmodule

// File: rtl/issue_pc_unit.sv
// Program counter register.
// Holds, steps by one word (2 bytes) or loads a target.
// Assumes: byte addressing; targets are even.
module issue_pc_unit
    import issue_seq_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         sel_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] WORD_STEP = PC_W'(2);

    logic [PC_W-1:0] pc_q;

    // PC update: zero on reset, otherwise hold, step or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (sel_i)
                PC_STEP: pc_q <= pc_q + WORD_STEP;
                PC_LOAD: pc_q <= target_i;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o = pc_q;

    // R1 / R2: the PC stays word aligned from reset on.
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i != PC_LOAD) |=> (pc_q[0] == $past(pc_q[0])));

endmodule

// File: rtl/issue_seq_ctrl.sv
// Issue state machine.
// Decides per cycle: execute, second word, bubble, plus the PC action.
// Assumes: cond_i is valid in the issue cycle of skips and conditional branches.
module issue_seq_ctrl
    import issue_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_class_e  cls_i,
    input  logic       cond_i,
    output seq_state_e state_o,
    output logic       exec_o,
    output logic       nop_o,
    output logic       last_o,
    output pc_sel_e    pc_sel_o
);

    seq_state_e st_q, st_d;

    // Next state and per-cycle strobes.
    always_comb begin
        st_d     = st_q;
        exec_o   = 1'b0;
        nop_o    = 1'b0;
        last_o   = 1'b0;
        pc_sel_o = PC_STEP;
        case (st_q)
            ST_ISSUE: begin
                case (cls_i)
                    CL_STRAY: begin
                        nop_o  = 1'b1;
                        last_o = 1'b1;
                    end
                    CL_NORMAL: begin
                        exec_o = 1'b1;
                        last_o = 1'b1;
                    end
                    CL_DWORD: begin
                        exec_o = 1'b1;
                        st_d   = ST_DW2;
                    end
                    CL_SKIP: begin
                        exec_o = 1'b1;
                        if (cond_i) st_d   = ST_SK1;
                        else        last_o = 1'b1;
                    end
                    CL_CBR: begin
                        exec_o = 1'b1;
                        if (cond_i) begin
                            pc_sel_o = PC_LOAD;
                            st_d     = ST_FL1;
                        end else begin
                            last_o = 1'b1;
                        end
                    end
                    CL_JUMP: begin
                        exec_o   = 1'b1;
                        pc_sel_o = PC_LOAD;
                        st_d     = ST_FL1;
                    end
                    CL_RET: begin
                        exec_o   = 1'b1;
                        pc_sel_o = PC_LOAD;
                        st_d     = ST_FL2;
                    end
                    default: begin
                        exec_o = 1'b1;
                        st_d   = ST_FL1;
                    end
                endcase
            end
            ST_DW2: begin
                last_o = 1'b1;
                st_d   = ST_ISSUE;
            end
            ST_SK1: begin
                nop_o = 1'b1;
                if (cls_i == CL_DWORD) begin
                    st_d = ST_SK2;
                end else begin
                    last_o = 1'b1;
                    st_d   = ST_ISSUE;
                end
            end
            ST_SK2: begin
                nop_o  = 1'b1;
                last_o = 1'b1;
                st_d   = ST_ISSUE;
            end
            ST_FL2: begin
                nop_o    = 1'b1;
                pc_sel_o = PC_HOLD;
                st_d     = ST_FL1;
            end
            ST_FL1: begin
                nop_o    = 1'b1;
                pc_sel_o = PC_HOLD;
                last_o   = 1'b1;
                st_d     = ST_ISSUE;
            end
            default: begin
                pc_sel_o = PC_HOLD;
                st_d     = ST_ISSUE;
            end
        endcase
    end

    // State register, cleared to issue on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ISSUE;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    // R11: the cycle after a last cycle is always an issue cycle.
    p_last_then_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (st_q == ST_ISSUE));

    // R9: a return is followed by a bubble that is not final.
    p_ret_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ISSUE && cls_i == CL_RET) |=> (nop_o && !last_o));

    // R6: skipping the head of a two-word instruction leaves one more bubble.
    p_skip_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SK1 && cls_i == CL_DWORD) |=> (nop_o && last_o));

    // R3: the second word cycle is neither executed nor a bubble.
    p_second_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ISSUE && cls_i == CL_DWORD) |=> (!exec_o && !nop_o && last_o));

endmodule

// File: rtl/issue_cyc_tally.sv
// Cycle tally.
// Counts the cycles of the instruction in flight and reports the total on its last cycle.
// Assumes: no instruction lasts more than three cycles.
module issue_cyc_tally #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_i,
    output logic [CNT_W-1:0] ncyc_o
);

    logic [CNT_W-1:0] run_q;

    // Cycles already spent on the current instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (last_i) run_q <= '0;
        else             run_q <= run_q + CNT_W'(1);
    end

    assign ncyc_o = run_q + CNT_W'(1);

    // R11: a third cycle is always the final one.
    p_max_three_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CNT_W'(2)) |-> last_i);

endmodule

// File: rtl/issue_seq_top.sv
// Instruction issue and skip sequencer, top level.
// Classifies the fetched word, runs the issue state machine, drives the PC
// and reports the cycle count of each instruction.
// Assumes: word_i is the word at pc_o in the same cycle; cond_i and target_i
// belong to the word being issued.
module issue_seq_top
    import issue_seq_pkg::*;
#(
    parameter int unsigned        WORD_W    = 24,
    parameter int unsigned        OPC_W     = 8,
    parameter int unsigned        PC_W      = 16,
    parameter logic [6*OPC_W-1:0] CLS_MATCH = 48'hB8_08_04_30_A0_02,
    parameter logic [6*OPC_W-1:0] CLS_MASK  = 48'hF8_FE_FC_F0_F0_FE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              cond_i,
    input  logic [PC_W-1:0]   target_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              exec_o,
    output logic              nop_o,
    output logic              last_o,
    output logic [1:0]        ncyc_o
);

    localparam int unsigned OPC_LSB = WORD_W - OPC_W;

    op_class_e  cls;
    seq_state_e state;
    pc_sel_e    pc_sel;

    issue_opc_class #(
        .OPC_W     (OPC_W),
        .CLS_MATCH (CLS_MATCH),
        .CLS_MASK  (CLS_MASK)
    ) u_class (
        .opc_i (word_i[WORD_W-1:OPC_LSB]),
        .cls_o (cls)
    );

    issue_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls_i    (cls),
        .cond_i   (cond_i),
        .state_o  (state),
        .exec_o   (exec_o),
        .nop_o    (nop_o),
        .last_o   (last_o),
        .pc_sel_o (pc_sel)
    );

    issue_pc_unit #(
        .PC_W (PC_W)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (pc_sel),
        .target_i (target_i),
        .pc_o     (pc_o)
    );

    issue_cyc_tally #(
        .CNT_W (2)
    ) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (last_o),
        .ncyc_o (ncyc_o)
    );

    // R2: a normal word moves the PC one word on.
    p_normal_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && cls == CL_NORMAL) |=> (pc_o == $past(pc_o) + PC_W'(2)));

    // R7: a taken conditional branch lands on the target sampled at issue.
    p_branch_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && cls == CL_CBR && cond_i) |=> (pc_o == $past(target_i) && nop_o));

    // R11: execute and bubble are exclusive, and a finishing count is never zero.
    p_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_o && nop_o) && (!last_o || ncyc_o != 2'd0));

endmodule

// File: tb/issue_seq_top_test.sv
`timescale 1ns/1ps
module issue_seq_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] word_i;
    logic        cond_i;
    logic [15:0] target_i;
    logic [15:0] pc_o;
    logic        exec_o, nop_o, last_o;
    logic [1:0]  ncyc_o;

    issue_seq_top uut (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .cond_i(cond_i),
        .target_i(target_i), .pc_o(pc_o), .exec_o(exec_o), .nop_o(nop_o),
        .last_o(last_o), .ncyc_o(ncyc_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] pc;
        bit          ex;
        bit          np;
        bit          ls;
        int          nc;
        string       tag;
    } rec_t;

    logic [23:0] mem [64];
    bit          cnd [64];
    logic [15:0] tgt [64];
    rec_t        q[$];
    logic [15:0] exp_pc;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;
    bit          did_mid = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d pc=%0d", tag, what, act, expv, pc_o);
        end
    endtask

    // Class by opcode ranges: 0 stray,1 normal,2 dword,3 skip,4 cbr,5 jump,6 ret,7 tbl
    function automatic int bcls(input logic [7:0] o);
        if (o == 8'h00)                 return 0;
        if (o inside {[8'h02:8'h03]})   return 2;
        if (o inside {[8'hA0:8'hAF]})   return 3;
        if (o inside {[8'h30:8'h3F]})   return 4;
        if (o inside {[8'h04:8'h07]})   return 5;
        if (o inside {[8'h08:8'h09]})   return 6;
        if (o inside {[8'hB8:8'hBF]})   return 7;
        return 1;
    endfunction

    task automatic push(input logic [15:0] p, input bit ex, input bit np,
                        input bit ls, input int nc, input string tag);
        rec_t r;
        r.pc = p; r.ex = ex; r.np = np; r.ls = ls; r.nc = nc; r.tag = tag;
        q.push_back(r);
    endtask

    // Expected cycle records for the instruction starting at exp_pc.
    task automatic plan();
        logic [15:0] a;
        logic [15:0] t;
        int          c;
        bit          cd;
        a  = exp_pc;
        c  = bcls(mem[a[6:1]][23:16]);
        cd = cnd[a[6:1]];
        t  = tgt[a[6:1]];
        case (c)
            0: begin push(a, 0, 1, 1, 1, "R1"); exp_pc = a + 2; end
            1: begin push(a, 1, 0, 1, 1, "R2"); exp_pc = a + 2; end
            2: begin
                push(a, 1, 0, 0, 0, "R3");
                push(a + 2, 0, 0, 1, 2, "R3");
                exp_pc = a + 4;
            end
            3: begin
                if (!cd) begin
                    push(a, 1, 0, 1, 1, "R4"); exp_pc = a + 2;
                end else if (bcls(mem[(a + 2) >> 1][23:16]) == 2) begin
                    push(a, 1, 0, 0, 0, "R6");
                    push(a + 2, 0, 1, 0, 0, "R6");
                    push(a + 4, 0, 1, 1, 3, "R6");
                    exp_pc = a + 6;
                end else begin
                    push(a, 1, 0, 0, 0, "R5");
                    push(a + 2, 0, 1, 1, 2, "R5");
                    exp_pc = a + 4;
                end
            end
            4: begin
                if (cd) begin
                    push(a, 1, 0, 0, 0, "R7");
                    push(t, 0, 1, 1, 2, "R7");
                    exp_pc = t;
                end else begin
                    push(a, 1, 0, 1, 1, "R7"); exp_pc = a + 2;
                end
            end
            5: begin
                push(a, 1, 0, 0, 0, "R8");
                push(t, 0, 1, 1, 2, "R8");
                exp_pc = t;
            end
            6: begin
                push(a, 1, 0, 0, 0, "R9");
                push(t, 0, 1, 0, 0, "R9");
                push(t, 0, 1, 1, 3, "R9");
                exp_pc = t;
            end
            default: begin
                push(a, 1, 0, 0, 0, "R10");
                push(a + 2, 0, 1, 1, 2, "R10");
                exp_pc = a + 2;
            end
        endcase
    endtask

    // One cycle: serve the fetch, then compare against the model.
    task automatic step();
        rec_t r;
        word_i   = mem[pc_o[6:1]];
        cond_i   = cnd[pc_o[6:1]];
        target_i = tgt[pc_o[6:1]];
        #0.5;
        if (q.size() == 0) plan();
        r = q.pop_front();
        chk(pc_o == r.pc, r.tag, "pc", pc_o, r.pc);
        chk(exec_o == r.ex, r.tag, "exec", exec_o, r.ex);
        chk(nop_o == r.np, r.tag, "nop", nop_o, r.np);
        chk(last_o == r.ls, "R11", "last", last_o, r.ls);
        chk(!(exec_o && nop_o), "R11", "exclusive", exec_o, 0);
        if (r.ls) chk(ncyc_o == r.nc[1:0], r.tag, "ncyc", ncyc_o, r.nc);
    endtask

    task automatic set_w(input int addr, input logic [23:0] w, input bit c,
                         input logic [15:0] t);
        mem[addr >> 1] = w;
        cnd[addr >> 1] = c;
        tgt[addr >> 1] = t;
    endtask

    // Reset for a few cycles, check the reset PC (R12), release and run the first cycle.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pc_o == 16'd0, "R12", "pc in reset", pc_o, 0);
        q.delete();
        exp_pc = 16'd0;
        rst_n  = 1'b1;
        step();
    endtask

    task automatic run(input int n, input bit midrst);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step();
            if (midrst && !did_mid && i >= 40 && q.size() == 2) begin
                did_mid = 1;
                @(negedge clk);
                do_reset();
            end
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        word_i   = '0;
        cond_i   = 1'b0;
        target_i = '0;
        for (int k = 0; k < 64; k++) begin
            mem[k] = 24'h10_0000;
            cnd[k] = 1'b0;
            tgt[k] = 16'd0;
        end
        set_w(0,  24'h10_1234, 0, 0);   // normal
        set_w(2,  24'h00_0000, 0, 0);   // stray tail word on its own
        set_w(4,  24'h02_0001, 0, 0);   // two-word head
        set_w(6,  24'h00_00AB, 0, 0);   // its tail
        set_w(8,  24'hA1_0000, 0, 0);   // skip, not taken
        set_w(10, 24'hA2_0000, 1, 0);   // skip over one word
        set_w(12, 24'h11_0000, 0, 0);
        set_w(14, 24'hA3_0000, 1, 0);   // skip over two-word
        set_w(16, 24'h03_0000, 0, 0);
        set_w(18, 24'h3A_0000, 1, 62);  // tail looks like a taken branch
        set_w(20, 24'hA4_0000, 1, 0);   // skip over a taken-looking branch
        set_w(22, 24'h31_0000, 1, 48);
        set_w(24, 24'h32_0000, 0, 60);  // branch, not taken
        set_w(26, 24'h33_0000, 1, 32);  // branch, taken
        set_w(32, 24'hB9_0000, 0, 0);   // table op
        set_w(34, 24'h02_0000, 0, 0);   // two-word with jump-looking tail
        set_w(36, 24'h04_0000, 0, 0);
        set_w(38, 24'h08_0000, 0, 44);  // return
        set_w(44, 24'h12_0000, 0, 0);
        set_w(46, 24'hA5_0000, 1, 0);   // skip over a stray tail
        set_w(48, 24'h00_0000, 0, 0);
        set_w(50, 24'h05_0000, 0, 0);   // jump to 0
        @(negedge clk);
        do_reset();
        run(120, 1'b1);
        // Second pass with skip and branch conditions inverted.
        foreach (cnd[k]) begin
            if (bcls(mem[k][23:16]) inside {3, 4}) cnd[k] = ~cnd[k];
        end
        @(negedge clk);
        do_reset();
        run(120, 1'b0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule